// File: doc/BRIEF.md
# Message-Signalled Interrupt Capability and Message Issuer

This block implements the message-signalled interrupt capability structure of a PCI function, together with the logic that turns interrupt requests from the device core into memory-write messages. Software reaches the structure through dword-addressed configuration accesses with byte enables. Offsets are relative to the capability base. The device core drives one level-style request line per vector. The block detects rising levels. It either records a pending bit for a masked vector or queues a message for an unmasked one.

Queued messages leave the block through a valid/ready request port. Each request carries a 64-bit target address and a 32-bit data word. When more than one vector is queued, the lowest-numbered vector goes first. Exactly one vector leaves per accepted handshake.

A write that unmasks a vector whose pending bit is set releases that vector's message at once, provided message signalling is enabled. Parameters choose 32- or 64-bit addressing, the number of vectors (1 to 32) and the value of the next-capability pointer.

Top module: `msi_cap_engine`

## Requirements
- R1: After reset, dword 0 reads {control[15:0], next pointer, 8'h05}. The control word has bit 8 (per-vector masking) set and bit 7 equal to the 64-bit mode. Bits 3:1 hold the smallest n with 2^n >= NUM_VEC. Bit 0 (enable) and bits 6:4 (enabled-vector field) are zero. Mask, pending and msg_valid are zero.
- R2: A write to dword 0 changes only control bit 0 and control bits 6:4 (wdata bits 16 and 22:20, under byte enable 2). The ID byte, the pointer byte, control bits 3:1 and 7, and the upper control byte never change.
- R3: The address-low register is dword 1. In 64-bit mode the address-high register is dword 2, data is dword 3, mask is dword 4 and pending is dword 5. In 32-bit mode data is dword 2, mask is dword 3 and pending is dword 4. Writes merge per byte enable, and reads are masked by the byte enables. Only data bits 15:0 and mask bits below NUM_VEC exist; the rest read zero. Pending ignores writes.
- R4: While enabled, a rising request on a masked vector sets that vector's pending bit and sends no message.
- R5: While enabled, a rising request on an unmasked vector queues its message and clears its pending bit. A held-high or falling request does nothing.
- R6: While enabled, a mask write that changes a bit from 1 to 0 while that vector's pending bit is set queues the message and clears the pending bit. While disabled, the pending bit stays set and no message is queued.
- R7: msg_data is {16'h0, data register with its low E bits replaced by the low E bits of the vector number}, where E is control bits 6:4.
- R8: msg_addr is {address-high, address-low} in 64-bit mode and {32'h0, address-low} in 32-bit mode.
- R9: msg_valid stays high until msg_ready is seen. Queued vectors are issued lowest number first, one per cycle with msg_valid and msg_ready both high.
- R10: While the enable bit is clear, rising requests are ignored: no pending bit is set and no message is queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_dw | input | 4 | Dword index relative to the capability base |
| cfg_be | input | 4 | Byte enables for the read and the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_dw, masked by cfg_be |
| irq_req | input | NUM_VEC | Per-vector request levels from the device core |
| msg_valid | output | 1 | A message request is offered |
| msg_ready | input | 1 | The message request is taken this cycle |
| msg_addr | output | 64 | Message target address |
| msg_data | output | 32 | Message data word |

## Verification
A wrong mask, pending or enable bit shows up in two ways. It appears in the next read of the mask or pending dword, one cycle after the offending write or request. It also shows as a message that appears or is missing on msg_valid in the cycle after the request edge or the unmasking write. A corrupted queue shows as the wrong vector number in the low bits of msg_data, or as a wrong issue order, on the cycle after each accepted handshake. Address and data register faults appear directly on msg_addr and msg_data with the first queued message. A random phase compares every cycle against a bench model, so a divergence is reported within one cycle.

// File: rtl/msi_pkg.sv
package msi_pkg;
  localparam logic [7:0] CAP_ID_MSI = 8'h05;

  // smallest n (0..5) with 2^n >= nv
  function automatic logic [2:0] mmc_of(input int nv);
    logic [2:0] r;
    r = 3'd5;
    for (int n = 5; n >= 0; n--) begin
      if ((1 << n) >= nv) r = 3'(n);
    end
    return r;
  endfunction

  function automatic logic [31:0] byte_merge(input logic [31:0] old_v,
                                             input logic [31:0] new_v,
                                             input logic [3:0]  be);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) begin
      r[b*8 +: 8] = be[b] ? new_v[b*8 +: 8] : old_v[b*8 +: 8];
    end
    return r;
  endfunction
endpackage

// File: rtl/msi_cfg_regs.sv
module msi_cfg_regs
  import msi_pkg::*;
#(
  parameter bit         ADDR64   = 1'b1,
  parameter int         NUM_VEC  = 8,
  parameter logic [7:0] NEXT_PTR = 8'h00
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [3:0]         dw,
  input  logic [3:0]         be,
  input  logic [31:0]        wdata,
  input  logic [NUM_VEC-1:0] pend_i,
  output logic [31:0]        rdata,
  output logic               en_o,
  output logic [2:0]         mme_o,
  output logic [63:0]        addr_o,
  output logic [15:0]        data_o,
  output logic [NUM_VEC-1:0] mask_o,
  output logic [NUM_VEC-1:0] mask_n_o
);
  localparam logic [3:0] DW_ALO  = 4'd1;
  localparam logic [3:0] DW_AHI  = 4'd2;
  localparam logic [3:0] DW_DATA = ADDR64 ? 4'd3 : 4'd2;
  localparam logic [3:0] DW_MASK = ADDR64 ? 4'd4 : 4'd3;
  localparam logic [3:0] DW_PEND = ADDR64 ? 4'd5 : 4'd4;
  localparam logic [2:0] MMC     = mmc_of(NUM_VEC);

  logic               en_q, en_n;
  logic [2:0]         mme_q, mme_n;
  logic [31:0]        alo_q, alo_n, ahi_q, ahi_n;
  logic [15:0]        data_q, data_n;
  logic [NUM_VEC-1:0] mask_q, mask_n;
  logic [15:0]        ctrl;
  logic [31:0]        rd_raw;

  // next-state
  always_comb begin
    en_n   = en_q;
    mme_n  = mme_q;
    alo_n  = alo_q;
    ahi_n  = ahi_q;
    data_n = data_q;
    mask_n = mask_q;
    if (wr_en) begin
      if (dw == 4'd0 && be[2]) begin
        en_n  = wdata[16];
        mme_n = wdata[22:20];
      end
      if (dw == DW_ALO) alo_n = byte_merge(alo_q, wdata, be);
      if (ADDR64 && dw == DW_AHI) ahi_n = byte_merge(ahi_q, wdata, be);
      if (dw == DW_DATA) begin
        for (int i = 0; i < 16; i++) if (be[i/8]) data_n[i] = wdata[i];
      end
      if (dw == DW_MASK) begin
        for (int i = 0; i < NUM_VEC; i++) if (be[i/8]) mask_n[i] = wdata[i];
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mme_q  <= 3'd0;
      alo_q  <= '0;
      ahi_q  <= '0;
      data_q <= '0;
      mask_q <= '0;
    end else if (wr_en) begin
      en_q   <= en_n;
      mme_q  <= mme_n;
      alo_q  <= alo_n;
      ahi_q  <= ahi_n;
      data_q <= data_n;
      mask_q <= mask_n;
    end
  end

  // read path
  always_comb begin
    ctrl   = {7'd0, 1'b1, ADDR64, mme_q, MMC, en_q};
    rd_raw = '0;
    if (dw == 4'd0)                rd_raw = {ctrl, NEXT_PTR, CAP_ID_MSI};
    else if (dw == DW_ALO)         rd_raw = alo_q;
    else if (ADDR64 && dw == DW_AHI) rd_raw = ahi_q;
    else if (dw == DW_DATA)        rd_raw = {16'd0, data_q};
    else if (dw == DW_MASK)        rd_raw = 32'(mask_q);
    else if (dw == DW_PEND)        rd_raw = 32'(pend_i);
  end

  assign rdata    = rd_raw & {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  assign en_o     = en_q;
  assign mme_o    = mme_q;
  assign addr_o   = {ahi_q, alo_q};
  assign data_o   = data_q;
  assign mask_o   = mask_q;
  assign mask_n_o = mask_n;
endmodule

// File: rtl/msi_vector_ctl.sv
module msi_vector_ctl #(
  parameter int NUM_VEC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC-1:0] irq_req,
  input  logic               en,
  input  logic [NUM_VEC-1:0] mask_q,
  input  logic [NUM_VEC-1:0] mask_n,
  input  logic [NUM_VEC-1:0] accept_1h,
  output logic [NUM_VEC-1:0] pend_o,
  output logic [NUM_VEC-1:0] queue_o
);
  logic [NUM_VEC-1:0] prev_q, pend_q, pend_n, queue_q, queue_n;
  logic [NUM_VEC-1:0] rise, pend_mid, release_v, send_add;

  always_comb begin
    rise      = en ? (irq_req & ~prev_q) : '0;
    pend_mid  = pend_q | (rise & mask_q);
    release_v = en ? (mask_q & ~mask_n & pend_mid) : '0;
    send_add  = (rise & ~mask_q) | release_v;
    pend_n    = pend_mid & ~send_add;
    queue_n   = (queue_q & ~accept_1h) | send_add;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      pend_q  <= '0;
      queue_q <= '0;
    end else begin
      prev_q  <= irq_req;
      pend_q  <= pend_n;
      queue_q <= queue_n;
    end
  end

  assign pend_o  = pend_q;
  assign queue_o = queue_q;
endmodule

// File: rtl/msi_msg_fmt.sv
module msi_msg_fmt #(
  parameter int NUM_VEC = 8
) (
  input  logic [NUM_VEC-1:0] queue,
  input  logic [2:0]         mme,
  input  logic [63:0]        addr,
  input  logic [15:0]        data,
  input  logic               ready,
  output logic               valid,
  output logic [63:0]        msg_addr,
  output logic [31:0]        msg_data,
  output logic [NUM_VEC-1:0] accept_1h
);
  localparam int VW = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;

  logic [VW-1:0]      vec;
  logic [NUM_VEC-1:0] lowest;
  logic [15:0]        low_mask;

  always_comb begin
    vec = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--) begin
      if (queue[i]) vec = VW'(i);
    end
  end

  assign lowest    = queue & (~queue + 1'b1);
  assign valid     = |queue;
  assign accept_1h = (valid && ready) ? lowest : '0;
  assign low_mask  = (16'd1 << mme) - 16'd1;
  assign msg_addr  = addr;
  assign msg_data  = {16'd0, (data & ~low_mask) | (16'(vec) & low_mask)};
endmodule

// File: rtl/msi_cap_engine.sv
module msi_cap_engine #(
  parameter bit         ADDR64   = 1'b1,
  parameter int         NUM_VEC  = 8,
  parameter logic [7:0] NEXT_PTR = 8'h00
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr_en,
  input  logic [3:0]         cfg_dw,
  input  logic [3:0]         cfg_be,
  input  logic [31:0]        cfg_wdata,
  output logic [31:0]        cfg_rdata,
  input  logic [NUM_VEC-1:0] irq_req,
  output logic               msg_valid,
  input  logic               msg_ready,
  output logic [63:0]        msg_addr,
  output logic [31:0]        msg_data
);
  logic               en_w;
  logic [2:0]         mme_w;
  logic [63:0]        addr_w;
  logic [15:0]        data_w;
  logic [NUM_VEC-1:0] mask_w, mask_n_w, pend_w, queue_w, accept_w;

  msi_cfg_regs #(.ADDR64(ADDR64), .NUM_VEC(NUM_VEC), .NEXT_PTR(NEXT_PTR)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .dw(cfg_dw), .be(cfg_be),
    .wdata(cfg_wdata), .pend_i(pend_w), .rdata(cfg_rdata), .en_o(en_w),
    .mme_o(mme_w), .addr_o(addr_w), .data_o(data_w), .mask_o(mask_w),
    .mask_n_o(mask_n_w)
  );

  msi_vector_ctl #(.NUM_VEC(NUM_VEC)) u_vec (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .en(en_w), .mask_q(mask_w),
    .mask_n(mask_n_w), .accept_1h(accept_w), .pend_o(pend_w), .queue_o(queue_w)
  );

  msi_msg_fmt #(.NUM_VEC(NUM_VEC)) u_fmt (
    .queue(queue_w), .mme(mme_w), .addr(addr_w), .data(data_w),
    .ready(msg_ready), .valid(msg_valid), .msg_addr(msg_addr),
    .msg_data(msg_data), .accept_1h(accept_w)
  );
endmodule

// File: rtl/msi_cap_checker.sv
module msi_cap_checker #(
  parameter int NUM_VEC = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [3:0]         cfg_dw,
  input logic [3:0]         cfg_be,
  input logic [31:0]        cfg_rdata,
  input logic               msg_valid,
  input logic               msg_ready,
  input logic               en,
  input logic [NUM_VEC-1:0] mask,
  input logic [NUM_VEC-1:0] pend
);
  // R2: the ID byte never changes
  a_r2_id_const: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_dw == 4'd0 && cfg_be[0]) |-> (cfg_rdata[7:0] == 8'h05));

  // R9: an offered message is held until taken
  a_r9_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> msg_valid);

  // R10: with the enable clear, an idle port stays idle
  a_r10_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !msg_valid) |=> !msg_valid);

  // R4: a pending bit only appears for a vector that was masked
  a_r4_pend_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(mask)) == '0));
endmodule

bind msi_cap_engine msi_cap_checker #(.NUM_VEC(NUM_VEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_dw(cfg_dw), .cfg_be(cfg_be),
  .cfg_rdata(cfg_rdata), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .en(en_w), .mask(mask_w), .pend(pend_w)
);

// File: tb/test_msi_cap_engine.sv
module test_msi_cap_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [3:0]  cfg_dw = '0, cfg_be = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic [7:0]  irq_req = '0;
  logic        msg_valid, msg_ready = 1'b0;
  logic [63:0] msg_addr;
  logic [31:0] msg_data;

  logic        b_wr = 1'b0;
  logic [3:0]  b_dw = '0, b_be = '0;
  logic [31:0] b_wd = '0, b_rd;
  logic [2:0]  b_irq = '0;
  logic        b_valid;
  logic [63:0] b_addr;
  logic [31:0] b_data;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  msi_cap_engine #(.ADDR64(1'b1), .NUM_VEC(8), .NEXT_PTR(8'h70)) i_msi_cap_engine (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_dw(cfg_dw),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .irq_req(irq_req), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data));

  msi_cap_engine #(.ADDR64(1'b0), .NUM_VEC(3), .NEXT_PTR(8'h40)) i_msi_cap_engine_a32 (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(b_wr), .cfg_dw(b_dw),
    .cfg_be(b_be), .cfg_wdata(b_wd), .cfg_rdata(b_rd),
    .irq_req(b_irq), .msg_valid(b_valid), .msg_ready(1'b0),
    .msg_addr(b_addr), .msg_data(b_data));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] dw, input logic [3:0] be, input logic [31:0] d);
    cfg_wr_en = 1'b1; cfg_dw = dw; cfg_be = be; cfg_wdata = d;
    tick();
    cfg_wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] dw, input logic [3:0] be,
                        input logic [31:0] exp);
    cfg_dw = dw; cfg_be = be;
    #1;
    chk(tag, 64'(cfg_rdata), 64'(exp));
  endtask

  function automatic logic [31:0] exp_data(input logic [15:0] d, input logic [2:0] e,
                                           input int v);
    logic [15:0] m;
    m = (16'd1 << e) - 16'd1;
    return {16'd0, (d & ~m) | (16'(v) & m)};
  endfunction

  // bench model for the random phase
  logic [7:0] m_mask, m_pend, m_queue, m_prev;

  function automatic int lowest_of(input logic [7:0] q);
    for (int i = 0; i < 8; i++) if (q[i]) return i;
    return 0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_chk("R1 dword0", 4'd0, 4'hF, 32'h0186_7005);
    rd_chk("R1 mask", 4'd4, 4'hF, 32'h0);
    rd_chk("R1 pend", 4'd5, 4'hF, 32'h0);
    chk("R1 valid", 64'(msg_valid), 64'd0);

    // R2 read-only fields
    wr(4'd0, 4'hF, 32'hFFFF_FFFF);
    rd_chk("R2 all-ones", 4'd0, 4'hF, 32'h01F7_7005);
    wr(4'd0, 4'b1011, 32'h0000_0000);
    rd_chk("R2 be2 off", 4'd0, 4'hF, 32'h01F7_7005);
    wr(4'd0, 4'b0100, 32'h0000_0000);
    rd_chk("R2 cleared", 4'd0, 4'hF, 32'h0186_7005);
    rd_chk("R3 read be", 4'd0, 4'b0010, 32'h0000_7000);

    // R3 layout and merges
    wr(4'd1, 4'hF, 32'hFEE0_1000);
    wr(4'd2, 4'hF, 32'h0000_0012);
    wr(4'd3, 4'hF, 32'hABCD_4A30);
    wr(4'd4, 4'hF, 32'hFFFF_FF0F);
    wr(4'd5, 4'hF, 32'hFFFF_FFFF);
    wr(4'd1, 4'b0001, 32'h0000_00AA);
    rd_chk("R3 alo merge", 4'd1, 4'hF, 32'hFEE0_10AA);
    wr(4'd1, 4'b0001, 32'h0000_0000);
    rd_chk("R3 ahi", 4'd2, 4'hF, 32'h0000_0012);
    rd_chk("R3 data", 4'd3, 4'hF, 32'h0000_4A30);
    rd_chk("R3 mask", 4'd4, 4'hF, 32'h0000_000F);
    rd_chk("R3 pend ro", 4'd5, 4'hF, 32'h0);

    // R10 disabled edge ignored
    irq_req = 8'h81; tick();
    chk("R10 no msg", 64'(msg_valid), 64'd0);
    rd_chk("R10 no pend", 4'd5, 4'hF, 32'h0);
    irq_req = 8'h00; tick();

    // enable, E=3
    wr(4'd0, 4'b0100, 32'h0031_0000);

    // R5, R7, R8, R9 single unmasked vector
    irq_req = 8'h20; tick();
    chk("R5 valid", 64'(msg_valid), 64'd1);
    chk("R8 addr64", msg_addr, 64'h0000_0012_FEE0_1000);
    chk("R7 data v5", 64'(msg_data), 64'(exp_data(16'h4A30, 3'd3, 5)));
    tick(); tick();
    chk("R9 held", 64'(msg_valid), 64'd1);
    msg_ready = 1'b1; tick(); msg_ready = 1'b0;
    chk("R9 taken", 64'(msg_valid), 64'd0);
    irq_req = 8'h00; tick();
    chk("R5 fall quiet", 64'(msg_valid), 64'd0);

    // R4 masked vector
    irq_req = 8'h04; tick();
    chk("R4 no msg", 64'(msg_valid), 64'd0);
    rd_chk("R4 pend", 4'd5, 4'hF, 32'h04);
    irq_req = 8'h00; tick();
    rd_chk("R5 fall keeps pend", 4'd5, 4'hF, 32'h04);

    // R9 ordering
    irq_req = 8'h50; tick();
    chk("R9 first v4", 64'(msg_data), 64'(exp_data(16'h4A30, 3'd3, 4)));
    msg_ready = 1'b1; tick();
    chk("R9 second v6", 64'(msg_data), 64'(exp_data(16'h4A30, 3'd3, 6)));
    chk("R9 second valid", 64'(msg_valid), 64'd1);
    tick(); msg_ready = 1'b0;
    chk("R9 drained", 64'(msg_valid), 64'd0);
    irq_req = 8'h00; tick();

    // R6 release by unmasking
    wr(4'd4, 4'b0001, 32'h0000_000B);
    chk("R6 release valid", 64'(msg_valid), 64'd1);
    chk("R6 release v2", 64'(msg_data), 64'(exp_data(16'h4A30, 3'd3, 2)));
    rd_chk("R6 pend cleared", 4'd5, 4'hF, 32'h0);
    msg_ready = 1'b1; tick(); msg_ready = 1'b0;

    // R6 disabled release keeps pending
    irq_req = 8'h02; tick();
    rd_chk("R4 pend v1", 4'd5, 4'hF, 32'h02);
    wr(4'd0, 4'b0100, 32'h0030_0000);
    wr(4'd4, 4'b0001, 32'h0000_0009);
    chk("R6 disabled no msg", 64'(msg_valid), 64'd0);
    rd_chk("R6 disabled pend", 4'd5, 4'hF, 32'h02);
    irq_req = 8'h00; tick();

    // R7 E=0, R5 clears pend on unmasked edge
    wr(4'd0, 4'b0100, 32'h0001_0000);
    irq_req = 8'h02; tick();
    chk("R7 E0 data", 64'(msg_data), 64'h0000_4A30);
    rd_chk("R5 pend cleared", 4'd5, 4'hF, 32'h0);
    msg_ready = 1'b1; tick(); msg_ready = 1'b0;
    irq_req = 8'h00; tick();

    // random phase, E=5, mask 0
    wr(4'd0, 4'b0100, 32'h0051_0000);
    wr(4'd4, 4'b0001, 32'h0);
    m_mask = '0; m_pend = '0; m_queue = '0; m_prev = '0;
    void'($urandom(32'd7));
    for (int c = 0; c < 3000; c++) begin
      logic [7:0] irq_n, mnew, rise, pmid, rel, add, acc;
      logic       rdy, w;
      irq_n = 8'($urandom());
      rdy   = 1'($urandom());
      w     = ($urandom() % 6) == 0;
      mnew  = w ? 8'($urandom()) : m_mask;
      acc   = (rdy && m_queue != 0) ? (8'd1 << lowest_of(m_queue)) : 8'd0;
      rise  = irq_n & ~m_prev;
      pmid  = m_pend | (rise & m_mask);
      rel   = m_mask & ~mnew & pmid;
      add   = (rise & ~m_mask) | rel;
      irq_req = irq_n; msg_ready = rdy;
      cfg_wr_en = w; cfg_dw = 4'd4; cfg_be = 4'b0001; cfg_wdata = 32'(mnew);
      tick();
      cfg_wr_en = 1'b0;
      m_pend = pmid & ~add; m_queue = (m_queue & ~acc) | add;
      m_mask = mnew; m_prev = irq_n;
      chk("R9 rand valid", 64'(msg_valid), 64'(m_queue != 0));
      if (m_queue != 0)
        chk("R7 rand data", 64'(msg_data), 64'(exp_data(16'h4A30, 3'd5, lowest_of(m_queue))));
      if (c % 50 == 0) rd_chk("R6 rand pend", 4'd5, 4'hF, 32'(m_pend));
    end
    msg_ready = 1'b0; irq_req = '0;

    // 32-bit instance: R1, R3, R8
    b_dw = 4'd0; b_be = 4'hF; #1;
    chk("R1 a32 dword0", 64'(b_rd), 64'h0104_4005);
    b_wr = 1'b1; b_dw = 4'd1; b_wd = 32'h1234_5670; tick();
    b_dw = 4'd2; b_wd = 32'hFFFF_0100; tick();
    b_dw = 4'd3; b_wd = 32'hFFFF_FFF8; tick();
    b_dw = 4'd0; b_be = 4'b0100; b_wd = 32'h0001_0000; tick();
    b_wr = 1'b0; b_be = 4'hF;
    b_dw = 4'd2; #1; chk("R3 a32 data", 64'(b_rd), 64'h0000_0100);
    b_dw = 4'd3; #1; chk("R3 a32 mask", 64'(b_rd), 64'h0);
    b_irq = 3'b100; tick();
    chk("R8 a32 addr", b_addr, 64'h0000_0000_1234_5670);
    chk("R7 a32 data", 64'(b_data), 64'h0000_0100);
    b_dw = 4'd4; #1; chk("R3 a32 pend", 64'(b_rd), 64'h0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule